// File: doc/BRIEF.md
# SPI Real-Time-Clock Time Transfer Sequencer

This block is a hardware SPI master that moves the calendar time between a host and an external real-time-clock device. A one-cycle read command makes the block open a single chip-enable transaction. It addresses the time registers, clocks in seven BCD bytes and presents seconds, minutes, a 0–23 hour, day of month, month and a four-digit year as binary values. The day-of-week byte is clocked in and then dropped. A one-cycle write command latches binary time fields and converts them to BCD. The block then runs three separate transactions: it clears the device's write-protect bit, burst-writes the seven time registers, and sets write protect again.

The controller FSM has states IDLE, SETUP (chip enable high, waiting before the first clock), LAUNCH (starting a later byte), XFER (a byte in flight), HOLD (chip enable still high after the last clock) and GAP (chip enable low between transactions). Its transitions are: IDLE→SETUP on an accepted command; SETUP→XFER when the setup wait ends; XFER→LAUNCH when a byte ends and more remain; LAUNCH→XFER; XFER→HOLD after the last byte; HOLD→GAP when more transactions remain; HOLD→IDLE after the last one; GAP→SETUP when the gap wait ends. A byte shifter has its own states: IDLE, HIGH (SCK high) and LOW (SCK low). It also has these transitions: IDLE→HIGH on start; HIGH→LOW when the half period ends; LOW→HIGH for the next bit; LOW→IDLE after the eighth bit.

Top module: `rtc_spi_seq`

## Requirements
- R1: While spi_ce is low, spi_sck and spi_mosi are both low. After reset: busy=0, done=0, spi_ce=0, every read field is 0 and rd_year is 2000.
- R2: Every byte goes out most significant bit first as eight SCK pulses. Each SCK high phase and each low phase inside a byte lasts half_period clock cycles. MOSI changes only in the cycle in which SCK rises, or at the end of a byte when SCK is low.
- R3: MISO is sampled in the last clock cycle of each SCK high phase, and bits are assembled most significant first.
- R4: A read is one transaction. It sends address 0x00 and then clocks in seven bytes: seconds, minutes, hours, day of week, day of month, month, year. The day-of-week byte is discarded. The outputs are BCD-decoded as tens nibble × 10 + units nibble, using seconds bits 6:0, minutes bits 6:0, day bits 5:0 and month bits 4:0.
- R5: When bit 6 of the hours byte is 0, bits 5:0 hold a BCD hour from 0 to 23, and that value is reported.
- R6: When bit 6 of the hours byte is 1, the hour is in 12-hour form. Bit 5 is the PM flag and bits 4:0 are the BCD hour. 12 AM gives 0, 12 PM gives 12, any other PM hour gives hour+12, and any other AM hour is reported unchanged.
- R7: rd_year is the BCD year byte plus 2000. A write sends the BCD of wr_year − 2000.
- R8: A write runs three chip-enable transactions in this order: {0x8F, 0x00}, then {0x80, seconds, minutes, hour, day of week, day of month, month, year} with every field in BCD, then {0x8F, 0x40}.
- R9: spi_ce rises exactly CE_SETUP+1 cycles before the first SCK rise. It stays high at least CE_HOLD+1 cycles after the last SCK fall. It stays low at least CE_GAP+1 cycles between the transactions of one write.
- R10: busy rises in the cycle after a command is accepted and stays high until the edge at which spi_ce falls for the last time. At that edge, done pulses for exactly one cycle.
- R11: rd_req and wr_req are ignored while busy is high. They start no transaction and change no output.
- R12: If rd_req and wr_req are both high in the same idle cycle, the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | HP_W | SCK high and low time in clock cycles (0 is treated as 1) |
| rd_req | input | 1 | Start a time read (one-cycle pulse) |
| wr_req | input | 1 | Start a time write (one-cycle pulse) |
| wr_sec | input | 6 | Seconds to write, binary |
| wr_min | input | 6 | Minutes to write, binary |
| wr_hour | input | 5 | Hour to write, 0–23 binary |
| wr_wday | input | 3 | Day of week to write |
| wr_mday | input | 5 | Day of month to write |
| wr_month | input | 4 | Month to write |
| wr_year | input | YEAR_W | Full year to write, 2000–2099 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_sec | output | 6 | Seconds read |
| rd_min | output | 6 | Minutes read |
| rd_hour | output | 5 | Hour read, 0–23 |
| rd_mday | output | 5 | Day of month read |
| rd_month | output | 4 | Month read |
| rd_year | output | YEAR_W | Full year read |
| spi_ce | output | 1 | Chip enable, active high |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Reads are run against a device model loaded with 24-hour bytes and with each special 12-hour pattern: 12 AM, 12 PM, a plain PM hour and a plain AM hour. These separate the two hour decodings and the midnight and noon corners. Reads repeat at half periods of 1 to 4 to expose timing that depends on a fixed divider. A write is checked against the exact byte stream and transaction split seen by the model, and the model honours write protect, so a missing unlock leaves its registers unchanged. Commands raised while busy, and read and write raised together, show whether a second transaction or the wrong one is started.

// File: rtl/rtc_seq_pkg.sv
`timescale 1ns/1ps
package rtc_seq_pkg;

    localparam int NUM_TIME_REGS = 7;
    localparam int BURST_BYTES   = NUM_TIME_REGS + 1;
    localparam int WDAY_BYTE     = 4;
    localparam int NUM_KEEP      = NUM_TIME_REGS - 1;
    localparam int YEAR_BASE     = 2000;

    localparam logic [7:0] ADDR_TIME_RD = 8'h00;
    localparam logic [7:0] ADDR_TIME_WR = 8'h80;
    localparam logic [7:0] ADDR_CTRL_WR = 8'h8F;
    localparam logic [7:0] CTRL_UNLOCK  = 8'h00;
    localparam logic [7:0] CTRL_LOCK    = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LAUNCH,
        ST_XFER,
        ST_HOLD,
        ST_GAP
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_HIGH,
        SH_LOW
    } sh_state_t;

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    // burst byte position that feeds kept slot k (day of week skipped)
    function automatic int keep_to_byte(input int k);
        return (k < WDAY_BYTE - 1) ? k + 1 : k + 2;
    endfunction

endpackage

// File: rtl/rtc_spi_shifter.sv
`timescale 1ns/1ps
module rtc_spi_shifter
    import rtc_seq_pkg::*;
#(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HP_W-1:0] half_period,
    input  logic            start,
    input  logic [7:0]      tx_byte,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic [7:0]      rx_byte,
    output logic            byte_done
);

    sh_state_t       state, state_nx;
    logic [HP_W-1:0] cnt;
    logic [HP_W-1:0] hp_m1;
    logic [2:0]      bit_idx;
    logic [7:0]      tx_sr;
    logic [7:0]      rx_sr;

    assign hp_m1   = (half_period == '0) ? '0 : half_period - 1'b1;
    assign rx_byte = rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SH_IDLE: if (start) state_nx = SH_HIGH;
            SH_HIGH: if (cnt == '0) state_nx = SH_LOW;
            SH_LOW:  if (cnt == '0) state_nx = (bit_idx == 3'd7) ? SH_IDLE : SH_HIGH;
            default: state_nx = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck       <= 1'b0;
            mosi      <= 1'b0;
            cnt       <= '0;
            bit_idx   <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            unique case (state)
                SH_IDLE: begin
                    sck  <= 1'b0;
                    mosi <= 1'b0;
                    if (start) begin
                        sck     <= 1'b1;
                        mosi    <= tx_byte[7];
                        tx_sr   <= {tx_byte[6:0], 1'b0};
                        cnt     <= hp_m1;
                        bit_idx <= '0;
                    end
                end
                SH_HIGH: begin
                    if (cnt == '0) begin
                        sck   <= 1'b0;
                        rx_sr <= {rx_sr[6:0], miso};
                        cnt   <= hp_m1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SH_LOW: begin
                    if (cnt == '0) begin
                        if (bit_idx == 3'd7) begin
                            byte_done <= 1'b1;
                            mosi      <= 1'b0;
                        end else begin
                            sck     <= 1'b1;
                            mosi    <= tx_sr[7];
                            tx_sr   <= {tx_sr[6:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                            cnt     <= hp_m1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    sck  <= 1'b0;
                    mosi <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rtc_hour_decode.sv
`timescale 1ns/1ps
module rtc_hour_decode
    import rtc_seq_pkg::*;
(
    input  logic [7:0] raw_hour,
    output logic [4:0] hour
);

    logic [7:0] h12;
    logic [7:0] h24;
    logic       mode12;
    logic       pm;

    assign mode12 = (raw_hour & 8'h40) != 8'h00;
    assign pm     = (raw_hour & 8'h20) != 8'h00;
    assign h12    = bcd_to_bin(raw_hour & 8'h1F);
    assign h24    = bcd_to_bin(raw_hour & 8'h3F);

    always_comb begin
        if (mode12) begin
            if (h12 == 8'd12) hour = pm ? 5'd12 : 5'd0;
            else if (pm)      hour = 5'(h12 + 8'd12);
            else              hour = 5'(h12);
        end else begin
            hour = 5'(h24);
        end
    end

endmodule

// File: rtl/rtc_seq_ctrl.sv
`timescale 1ns/1ps
module rtc_seq_ctrl
    import rtc_seq_pkg::*;
#(
    parameter int CE_SETUP = 4,
    parameter int CE_HOLD  = 4,
    parameter int CE_GAP   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_req,
    input  logic                          wr_req,
    input  logic [NUM_TIME_REGS-1:0][7:0] wr_bcd,
    input  logic                          sh_done,
    input  logic [7:0]                    sh_rx,
    output logic                          sh_start,
    output logic [7:0]                    sh_tx,
    output logic [NUM_KEEP-1:0][7:0]      rd_raw,
    output logic                          ce,
    output logic                          busy,
    output logic                          done
);

    localparam int WAIT_MAX = (CE_SETUP > CE_HOLD)
                            ? ((CE_SETUP > CE_GAP) ? CE_SETUP : CE_GAP)
                            : ((CE_HOLD > CE_GAP) ? CE_HOLD : CE_GAP);
    localparam int WAIT_W   = $clog2(WAIT_MAX + 2);
    localparam int IDX_W    = $clog2(BURST_BYTES);

    seq_state_t                    state, state_nx;
    logic [WAIT_W-1:0]             wait_cnt;
    logic [IDX_W-1:0]              byte_idx;
    logic [1:0]                    txn;
    logic                          is_write;
    logic [NUM_TIME_REGS-1:0][7:0] wdata;
    logic [IDX_W-1:0]              last_byte;
    logic                          last_txn;
    logic                          cmd;

    assign cmd       = rd_req | wr_req;
    assign last_byte = (is_write && txn != 2'd1) ? IDX_W'(1) : IDX_W'(BURST_BYTES - 1);
    assign last_txn  = !is_write || (txn == 2'd2);
    assign sh_start  = (state == ST_LAUNCH) || (state == ST_SETUP && wait_cnt == '0);

    always_comb begin
        if (byte_idx == '0) begin
            if (!is_write)       sh_tx = ADDR_TIME_RD;
            else if (txn == 2'd1) sh_tx = ADDR_TIME_WR;
            else                 sh_tx = ADDR_CTRL_WR;
        end else if (is_write && txn == 2'd0) begin
            sh_tx = CTRL_UNLOCK;
        end else if (is_write && txn == 2'd2) begin
            sh_tx = CTRL_LOCK;
        end else if (is_write) begin
            sh_tx = wdata[3'(byte_idx - 1'b1)];
        end else begin
            sh_tx = 8'h00;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cmd) state_nx = ST_SETUP;
            ST_SETUP:  if (wait_cnt == '0) state_nx = ST_XFER;
            ST_LAUNCH: state_nx = ST_XFER;
            ST_XFER:   if (sh_done) state_nx = (byte_idx == last_byte) ? ST_HOLD : ST_LAUNCH;
            ST_HOLD:   if (wait_cnt == '0) state_nx = last_txn ? ST_IDLE : ST_GAP;
            ST_GAP:    if (wait_cnt == '0) state_nx = ST_SETUP;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            byte_idx <= '0;
            txn      <= '0;
            is_write <= 1'b0;
            wdata    <= '0;
            rd_raw   <= '0;
            ce       <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd) begin
                        is_write <= !rd_req;
                        wdata    <= wr_bcd;
                        txn      <= '0;
                        byte_idx <= '0;
                        wait_cnt <= WAIT_W'(CE_SETUP);
                        ce       <= 1'b1;
                        busy     <= 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
                end
                ST_LAUNCH: begin
                end
                ST_XFER: begin
                    if (sh_done) begin
                        if (!is_write) begin
                            for (int k = 0; k < NUM_KEEP; k++) begin
                                if (byte_idx == IDX_W'(keep_to_byte(k))) rd_raw[k] <= sh_rx;
                            end
                        end
                        if (byte_idx == last_byte) wait_cnt <= WAIT_W'(CE_HOLD);
                        else                       byte_idx <= byte_idx + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (wait_cnt == '0) begin
                        ce       <= 1'b0;
                        byte_idx <= '0;
                        if (last_txn) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            txn      <= txn + 1'b1;
                            wait_cnt <= WAIT_W'(CE_GAP);
                        end
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (wait_cnt == '0) begin
                        ce       <= 1'b1;
                        wait_cnt <= WAIT_W'(CE_SETUP);
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: begin
                    ce   <= 1'b0;
                    busy <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/rtc_spi_seq.sv
`timescale 1ns/1ps
module rtc_spi_seq
    import rtc_seq_pkg::*;
#(
    parameter int HP_W     = 8,
    parameter int YEAR_W   = 12,
    parameter int CE_SETUP = 4,
    parameter int CE_HOLD  = 4,
    parameter int CE_GAP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HP_W-1:0]   half_period,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [5:0]        wr_sec,
    input  logic [5:0]        wr_min,
    input  logic [4:0]        wr_hour,
    input  logic [2:0]        wr_wday,
    input  logic [4:0]        wr_mday,
    input  logic [3:0]        wr_month,
    input  logic [YEAR_W-1:0] wr_year,
    output logic              busy,
    output logic              done,
    output logic [5:0]        rd_sec,
    output logic [5:0]        rd_min,
    output logic [4:0]        rd_hour,
    output logic [4:0]        rd_mday,
    output logic [3:0]        rd_month,
    output logic [YEAR_W-1:0] rd_year,
    output logic              spi_ce,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic [NUM_TIME_REGS-1:0][6:0] wr_bin;
    logic [NUM_TIME_REGS-1:0][7:0] wr_bcd;
    logic [NUM_KEEP-1:0][7:0]      rd_raw;
    logic                          sh_start;
    logic                          sh_done;
    logic [7:0]                    sh_tx;
    logic [7:0]                    sh_rx;

    // binary fields in device register order
    assign wr_bin[0] = 7'(wr_sec);
    assign wr_bin[1] = 7'(wr_min);
    assign wr_bin[2] = 7'(wr_hour);
    assign wr_bin[3] = 7'(wr_wday);
    assign wr_bin[4] = 7'(wr_mday);
    assign wr_bin[5] = 7'(wr_month);
    assign wr_bin[6] = 7'(wr_year - YEAR_W'(YEAR_BASE));

    genvar g;
    generate
        for (g = 0; g < NUM_TIME_REGS; g++) begin : g_to_bcd
            assign wr_bcd[g] = bin_to_bcd(wr_bin[g]);
        end
    endgenerate

    // kept read slots: 0 sec, 1 min, 2 hour, 3 mday, 4 month, 5 year
    assign rd_sec   = 6'(bcd_to_bin(rd_raw[0] & 8'h7F));
    assign rd_min   = 6'(bcd_to_bin(rd_raw[1] & 8'h7F));
    assign rd_mday  = 5'(bcd_to_bin(rd_raw[3] & 8'h3F));
    assign rd_month = 4'(bcd_to_bin(rd_raw[4] & 8'h1F));
    assign rd_year  = YEAR_W'(bcd_to_bin(rd_raw[5])) + YEAR_W'(YEAR_BASE);

    rtc_hour_decode i_hour (
        .raw_hour (rd_raw[2]),
        .hour     (rd_hour)
    );

    rtc_seq_ctrl #(
        .CE_SETUP (CE_SETUP),
        .CE_HOLD  (CE_HOLD),
        .CE_GAP   (CE_GAP)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .wr_bcd   (wr_bcd),
        .sh_done  (sh_done),
        .sh_rx    (sh_rx),
        .sh_start (sh_start),
        .sh_tx    (sh_tx),
        .rd_raw   (rd_raw),
        .ce       (spi_ce),
        .busy     (busy),
        .done     (done)
    );

    rtc_spi_shifter #(
        .HP_W (HP_W)
    ) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_period (half_period),
        .start       (sh_start),
        .tx_byte     (sh_tx),
        .miso        (spi_miso),
        .sck         (spi_sck),
        .mosi        (spi_mosi),
        .rx_byte     (sh_rx),
        .byte_done   (sh_done)
    );

endmodule

// File: rtl/rtc_spi_seq_chk.sv
`timescale 1ns/1ps
module rtc_spi_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic wr_req,
    input logic busy,
    input logic done,
    input logic spi_ce,
    input logic spi_sck,
    input logic spi_mosi
);

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_ce |-> (!spi_sck && !spi_mosi));

    assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_ce_leads_sck_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_ce) |-> !spi_sck);

    assert_ce_within_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_ce);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_accept_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (rd_req || wr_req)) |=> busy);

endmodule

bind rtc_spi_seq rtc_spi_seq_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .busy     (busy),
    .done     (done),
    .spi_ce   (spi_ce),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi)
);

// File: tb/test_rtc_spi_seq.sv
`timescale 1ns/1ps
module test_rtc_spi_seq;

    localparam int HP_W = 8, YEAR_W = 12, SETUP = 4, HOLD = 4, GAP = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [HP_W-1:0] half_period = 8'd2;
    logic rd_req = 1'b0, wr_req = 1'b0;
    logic [5:0] wr_sec = '0, wr_min = '0;
    logic [4:0] wr_hour = '0, wr_mday = '0;
    logic [2:0] wr_wday = '0;
    logic [3:0] wr_month = '0;
    logic [YEAR_W-1:0] wr_year = 12'd2000;
    logic busy, done, spi_ce, spi_sck, spi_mosi;
    logic spi_miso = 1'b0;
    logic [5:0] rd_sec, rd_min;
    logic [4:0] rd_hour, rd_mday;
    logic [3:0] rd_month;
    logic [YEAR_W-1:0] rd_year;

    always #10 clk = ~clk;

    rtc_spi_seq #(.HP_W(HP_W), .YEAR_W(YEAR_W), .CE_SETUP(SETUP), .CE_HOLD(HOLD), .CE_GAP(GAP)) i_rtc_spi_seq (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .rd_req(rd_req), .wr_req(wr_req),
        .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_wday(wr_wday), .wr_mday(wr_mday),
        .wr_month(wr_month), .wr_year(wr_year), .busy(busy), .done(done), .rd_sec(rd_sec),
        .rd_min(rd_min), .rd_hour(rd_hour), .rd_mday(rd_mday), .rd_month(rd_month), .rd_year(rd_year),
        .spi_ce(spi_ce), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    int tests = 0, fails = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // ---------------- behavioural device model ----------------
    logic [7:0] regs [0:31];
    logic [7:0] log_q [$];
    int txn_q [$];
    int bitcnt = 0;
    logic [7:0] cur = '0, addr = '0;

    always @(posedge spi_ce) begin bitcnt = 0; addr = '0; end
    always @(negedge spi_ce) txn_q.push_back(bitcnt / 8);

    always @(negedge spi_sck) if (spi_ce) begin
        cur = {cur[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
            log_q.push_back(cur);
            if (bitcnt == 8) addr = cur;
            else if (addr[7]) begin
                int a;
                a = (int'(addr[6:0]) + bitcnt / 8 - 2) & 31;
                if (a == 15 || !regs[15][6]) regs[a] = cur;
            end
        end
    end

    always @(posedge spi_sck) if (spi_ce && bitcnt >= 8 && !addr[7]) begin
        int a;
        #10;
        a = (int'(addr[6:0]) + bitcnt / 8 - 1) & 31;
        spi_miso = regs[a][7 - bitcnt % 8];
    end

    // ---------------- per-clock protocol reference ----------------
    int mon_r1 = 0, mon_r2 = 0, mon_r9 = 0;
    int hi_run = 0, since_ce = 0, since_fall = 0, low_run = 0;
    bit prev_sck = 0, prev_ce = 0, first_pend = 0, mid = 0;

    always @(negedge clk) if (rst_n) begin
        if (!spi_ce && (spi_sck || spi_mosi)) begin
            mon_r1++; $display("FAIL R1 idle lines sck=%0d mosi=%0d expected 0", spi_sck, spi_mosi);
        end
        if (spi_sck) hi_run++;
        else begin
            if (prev_sck && hi_run != int'(half_period)) begin
                mon_r2++; $display("FAIL R2 high phase actual=%0d expected=%0d", hi_run, half_period);
            end
            hi_run = 0;
        end
        if (spi_ce && !prev_ce) begin
            if (mid && low_run < GAP + 1) begin
                mon_r9++; $display("FAIL R9 gap actual=%0d expected>=%0d", low_run, GAP + 1);
            end
            since_ce = 1; first_pend = 1;
        end else if (spi_ce) since_ce++;
        if (spi_sck && !prev_sck && first_pend) begin
            first_pend = 0;
            if (since_ce - 1 != SETUP + 1) begin
                mon_r9++; $display("FAIL R9 setup actual=%0d expected=%0d", since_ce - 1, SETUP + 1);
            end
        end
        if (!spi_sck && prev_sck) since_fall = 0; else since_fall++;
        if (!spi_ce && prev_ce) begin
            if (since_fall < HOLD + 1) begin
                mon_r9++; $display("FAIL R9 hold actual=%0d expected>=%0d", since_fall, HOLD + 1);
            end
            low_run = 1; mid = busy;
        end else if (!spi_ce) low_run++;
        prev_sck = spi_sck; prev_ce = spi_ce;
    end

    // ---------------- helpers ----------------
    function automatic int bcd2i(input int v); return (v / 16) * 10 + (v % 16); endfunction
    function automatic int i2bcd(input int v); return (v / 10) * 16 + (v % 10); endfunction
    function automatic int exp_hour(input int b);
        int d;
        if ((b & 'h40) != 0) begin
            d = bcd2i(b & 'h1F);
            if (d == 12) return ((b & 'h20) != 0) ? 12 : 0;
            return ((b & 'h20) != 0) ? d + 12 : d;
        end
        return bcd2i(b & 'h3F);
    endfunction

    // R10 and R11 checked here: busy after accept, one-cycle done, busy low at done
    task automatic run_cmd(input bit rd, input bit wr, input bit poke);
        log_q.delete(); txn_q.delete();
        @(negedge clk); rd_req = rd; wr_req = wr;
        @(negedge clk); rd_req = 0; wr_req = 0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            rd_req = 1; wr_req = 1;
            @(negedge clk); rd_req = 0; wr_req = 0;
        end
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", done, 1'b0);
    endtask

    task automatic load_time(input int s, input int m, input int h, input int wd, input int md, input int mo, input int y);
        regs[0] = 8'(s); regs[1] = 8'(m); regs[2] = 8'(h); regs[3] = 8'(wd);
        regs[4] = 8'(md); regs[5] = 8'(mo); regs[6] = 8'(y);
    endtask

    task automatic check_read(input string tag);
        chk(int'(rd_sec) == bcd2i(regs[0] & 'h7F), {tag, " R3 R4 seconds"}, rd_sec, bcd2i(regs[0] & 'h7F));
        chk(int'(rd_min) == bcd2i(regs[1] & 'h7F), {tag, " R4 minutes"}, rd_min, bcd2i(regs[1] & 'h7F));
        chk(int'(rd_hour) == exp_hour(regs[2]), {tag, " R5 R6 hour"}, rd_hour, exp_hour(regs[2]));
        chk(int'(rd_mday) == bcd2i(regs[4] & 'h3F), {tag, " R4 mday"}, rd_mday, bcd2i(regs[4] & 'h3F));
        chk(int'(rd_month) == bcd2i(regs[5] & 'h1F), {tag, " R4 month"}, rd_month, bcd2i(regs[5] & 'h1F));
        chk(int'(rd_year) == bcd2i(regs[6]) + 2000, {tag, " R7 year"}, rd_year, bcd2i(regs[6]) + 2000);
        chk(txn_q.size() == 1 && txn_q[0] == 8, {tag, " R4 one 8-byte transaction"}, txn_q.size(), 1);
        chk(log_q.size() > 0 && log_q[0] == 8'h00, {tag, " R4 address 0x00"}, log_q.size() > 0 ? log_q[0] : -1, 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int exp_bytes [$];
        for (int i = 0; i < 32; i++) regs[i] = 8'h00;
        regs[15] = 8'h40;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_ce == 0 && busy == 0 && done == 0, "R1 reset ce/busy/done", {spi_ce, busy, done}, 0);
        chk(rd_sec == 0 && rd_hour == 0 && rd_year == 2000, "R1 reset fields", rd_year, 2000);

        // R5 24-hour read, half period 2
        half_period = 8'd2;
        load_time('h59, 'h07, 'h23, 'h05, 'h31, 'h12, 'h99);
        run_cmd(1, 0, 0); check_read("24h");
        // R6 12 AM -> 0, half period 1
        half_period = 8'd1;
        load_time('h00, 'h59, 'h52, 'h01, 'h01, 'h01, 'h00);
        run_cmd(1, 0, 0); check_read("12AM");
        // R6 12 PM -> 12, half period 3
        half_period = 8'd3;
        load_time('h30, 'h15, 'h72, 'h07, 'h15, 'h06, 'h42);
        run_cmd(1, 0, 0); check_read("12PM");
        // R6 9 PM -> 21, half period 4
        half_period = 8'd4;
        load_time('h01, 'h44, 'h69, 'h02, 'h28, 'h02, 'h24);
        run_cmd(1, 0, 0); check_read("9PM");
        // R6 1 AM -> 1
        half_period = 8'd2;
        load_time('h17, 'h33, 'h41, 'h03, 'h09, 'h11, 'h07);
        run_cmd(1, 0, 0); check_read("1AM");

        // R8 write sequence with R7 year offset
        wr_sec = 6'd45; wr_min = 6'd30; wr_hour = 5'd17; wr_wday = 3'd3;
        wr_mday = 5'd28; wr_month = 4'd2; wr_year = 12'd2024;
        run_cmd(0, 1, 0);
        chk(txn_q.size() == 3, "R8 three transactions", txn_q.size(), 3);
        chk(txn_q.size() == 3 && txn_q[0] == 2 && txn_q[1] == 8 && txn_q[2] == 2,
            "R8 transaction lengths", txn_q.size() == 3 ? txn_q[1] : -1, 8);
        exp_bytes = '{'h8F, 'h00, 'h80, i2bcd(45), i2bcd(30), i2bcd(17), i2bcd(3),
                      i2bcd(28), i2bcd(2), i2bcd(24), 'h8F, 'h40};
        for (int i = 0; i < 12; i++)
            chk(i < log_q.size() && int'(log_q[i]) == exp_bytes[i], $sformatf("R8 byte %0d", i),
                i < log_q.size() ? int'(log_q[i]) : -1, exp_bytes[i]);
        chk(int'(regs[6]) == 'h24, "R7 written year byte", regs[6], 'h24);
        chk(int'(regs[2]) == 'h17, "R8 device hour stored", regs[2], 'h17);
        chk(regs[15] == 8'h40, "R8 protect restored", regs[15], 'h40);

        // R11 commands while busy ignored
        load_time('h11, 'h22, 'h08, 'h04, 'h19, 'h10, 'h31);
        run_cmd(1, 0, 1);
        chk(txn_q.size() == 1, "R11 no extra transaction", txn_q.size(), 1);
        check_read("R11");
        repeat (5) @(negedge clk);
        chk(busy == 0 && spi_ce == 0, "R11 stays idle after done", busy, 0);

        // R12 simultaneous read and write -> read
        run_cmd(1, 1, 0);
        chk(txn_q.size() == 1 && log_q[0] == 8'h00, "R12 read chosen", txn_q.size(), 1);
        chk(int'(regs[0]) == 'h11, "R12 device untouched", regs[0], 'h11);

        chk(mon_r1 == 0, "R1 per-clock idle lines", mon_r1, 0);
        chk(mon_r2 == 0, "R2 per-clock SCK phases", mon_r2, 0);
        chk(mon_r9 == 0, "R9 per-clock CE timing", mon_r9, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule